// File: doc/BRIEF.md
# Ping-Pong Receive Buffer for a Bulk OUT Endpoint

This block gives a bulk OUT endpoint two packet buffers. Each buffer holds up to one maximum-size packet. While the serial-side logic streams the bytes of one packet into a free buffer, the processor drains the previous packet from the other. Each buffer carries a full flag and a latched byte count. The processor sees one buffer at a time. A size output reports how many valid bytes that buffer holds, or zero when it holds no completed packet.

The processor hands a buffer back by pulsing a trigger input. This frees the buffer, moves the processor to the other buffer, rewinds its read pointer, and makes the size output show the count of the newly selected buffer. A read past the reported size is refused, and an error pulse reports it. A clear input throws away stale packets, for example after the cable is plugged back in. The clear never touches a buffer that is part-way through receiving a packet, so that packet completes intact.

Top module: `rx_pingpong_fifo`

## Requirements
- R1: Synchronous reset leaves `rx_size` at 0, `usb_busy` at 0 and `cpu_rd_err` at 0, with both buffers empty.
- R2: Bytes accepted on `usb_wr_en` are stored in arrival order in an empty buffer. A `usb_pkt_done` pulse marks that buffer full and latches its byte count, which includes a byte written in the same cycle. If the processor currently owns that buffer, `rx_size` shows the count from the next cycle on.
- R3: `cpu_rd_data` always presents the byte at the read pointer of the processor's buffer. Each `cpu_rd_en` cycle with the pointer below `rx_size` moves the pointer to the next byte.
- R4: A `cpu_rd_en` cycle with the pointer already at `rx_size` does not move the pointer, so `cpu_rd_data` is unchanged. `cpu_rd_err` is 1 in the following cycle only.
- R5: A `cpu_trig` pulse frees the processor's buffer, switches the processor to the other buffer and rewinds the read pointer to its first byte. `rx_size` then shows that buffer's count, or 0 when it holds no completed packet.
- R6: Packets can be received into one buffer while the processor drains the other. Packets reach the processor in the order they completed.
- R7: While both buffers are full, `usb_busy` is 1, and both written bytes and `usb_pkt_done` are ignored. After a trigger frees a buffer, `usb_busy` drops and the next packet goes into the freed buffer.
- R8: A `cpu_clear` pulse empties every buffer except one that is part-way through receiving a packet, and rewinds the read pointer. The receiving buffer keeps its bytes, and its packet completes with the full count.
- R9: Bytes beyond `MAX_PKT` within one packet are dropped, and the count latched for that packet is `MAX_PKT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| usb_wr_en | input | 1 | Serial side presents a received byte |
| usb_wr_data | input | DATA_W | Received byte |
| usb_pkt_done | input | 1 | Current packet is complete |
| usb_busy | output | 1 | Both buffers full; the serial side must refuse the packet |
| cpu_rd_en | input | 1 | Processor consumes the byte on `cpu_rd_data` |
| cpu_rd_data | output | DATA_W | Byte at the processor read pointer |
| cpu_rd_err | output | 1 | One-cycle pulse after a read beyond `rx_size` |
| cpu_trig | input | 1 | Release the current buffer and switch to the other |
| cpu_clear | input | 1 | Discard stored packets not being received |
| rx_size | output | $clog2(MAX_PKT+1) | Byte count of the processor's buffer |

## Verification
The bench builds the block with `MAX_PKT` set to 8 and `DATA_W` set to 8. With so small a packet size, one packet of eleven bytes shows the truncation at the packet limit. Filling both buffers so the endpoint refuses traffic also takes only a few cycles. Because the read side is short as well, every overread attempt and every clear that falls in the middle of a packet sits close to a buffer boundary.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

    localparam int NUM_BANKS = 2;

    typedef enum logic {
        BANK0 = 1'b0,
        BANK1 = 1'b1
    } bank_id_t;

    typedef struct packed {
        logic rd;
        logic trig;
        logic clear;
    } cpu_cmd_t;

    typedef struct packed {
        logic wr;
        logic done;
    } usb_cmd_t;

    function automatic bank_id_t peer(input bank_id_t b);
        return (b == BANK0) ? BANK1 : BANK0;
    endfunction

endpackage

// File: rtl/rxpp_bank.sv
module rxpp_bank #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_full,
    input  logic [CNT_W-1:0]  set_cnt,
    input  logic              release_i,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic [CNT_W-1:0]  cnt
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // completion wins over a release in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            cnt  <= '0;
        end else if (set_full) begin
            full <= 1'b1;
            cnt  <= set_cnt;
        end else if (release_i) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/rxpp_usb_side.sv
module rxpp_usb_side
    import rxpp_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int CNT_W   = $clog2(MAX_PKT + 1),
    parameter int ADDR_W  = $clog2(MAX_PKT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  usb_cmd_t             cmd,
    input  logic [NUM_BANKS-1:0] bank_full,
    output logic                 busy,
    output bank_id_t             tgt,
    output logic                 wr_accept,
    output logic                 done_accept,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [CNT_W-1:0]     done_cnt,
    output logic                 rx_active
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PKT);

    logic [CNT_W-1:0] wr_ptr;
    bank_id_t         fill_sel;
    logic             room;

    assign busy = &bank_full;

    // an idle receiver steers toward whichever bank is free
    always_comb begin
        if (rx_active) begin
            tgt = fill_sel;
        end else if (bank_full[fill_sel]) begin
            tgt = peer(fill_sel);
        end else begin
            tgt = fill_sel;
        end
    end

    assign room        = wr_ptr < LIMIT;
    assign wr_accept   = cmd.wr && !busy && room;
    assign done_accept = cmd.done && !busy;
    assign done_cnt    = wr_ptr + CNT_W'(wr_accept);
    assign wr_addr     = wr_ptr[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rx_active <= 1'b0;
            fill_sel  <= BANK0;
        end else if (done_accept) begin
            wr_ptr    <= '0;
            rx_active <= 1'b0;
            fill_sel  <= peer(tgt);
        end else if (wr_accept) begin
            wr_ptr    <= wr_ptr + 1'b1;
            rx_active <= 1'b1;
            fill_sel  <= tgt;
        end
    end

endmodule

// File: rtl/rxpp_cpu_side.sv
module rxpp_cpu_side
    import rxpp_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int CNT_W   = $clog2(MAX_PKT + 1),
    parameter int ADDR_W  = $clog2(MAX_PKT)
) (
    input  logic              clk,
    input  logic              rst,
    input  cpu_cmd_t          cmd,
    input  logic [CNT_W-1:0]  rx_size,
    output bank_id_t          cpu_sel,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_err,
    output logic              trig_accept
);

    logic [CNT_W-1:0] rd_ptr;
    logic             in_range;
    logic             rd_accept;

    assign in_range    = rd_ptr < rx_size;
    assign trig_accept = cmd.trig && !cmd.clear;
    assign rd_accept   = cmd.rd && in_range && !cmd.trig && !cmd.clear;
    assign rd_addr     = rd_ptr[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr  <= '0;
            cpu_sel <= BANK0;
        end else if (cmd.clear) begin
            rd_ptr  <= '0;
        end else if (trig_accept) begin
            rd_ptr  <= '0;
            cpu_sel <= peer(cpu_sel);
        end else if (rd_accept) begin
            rd_ptr  <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_err <= 1'b0;
        end else begin
            rd_err <= cmd.rd && !in_range;
        end
    end

endmodule

// File: rtl/rx_pingpong_fifo.sv
module rx_pingpong_fifo
    import rxpp_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MAX_PKT = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           usb_wr_en,
    input  logic [DATA_W-1:0]              usb_wr_data,
    input  logic                           usb_pkt_done,
    output logic                           usb_busy,
    input  logic                           cpu_rd_en,
    output logic [DATA_W-1:0]              cpu_rd_data,
    output logic                           cpu_rd_err,
    input  logic                           cpu_trig,
    input  logic                           cpu_clear,
    output logic [$clog2(MAX_PKT+1)-1:0]   rx_size
);

    localparam int CNT_W  = $clog2(MAX_PKT + 1);
    localparam int ADDR_W = $clog2(MAX_PKT);

    usb_cmd_t             ucmd;
    cpu_cmd_t             ccmd;
    logic [NUM_BANKS-1:0] bank_full;
    logic [CNT_W-1:0]     bank_cnt  [NUM_BANKS];
    logic [DATA_W-1:0]    bank_data [NUM_BANKS];
    bank_id_t             tgt;
    bank_id_t             cpu_sel;
    logic                 wr_accept;
    logic                 done_accept;
    logic [ADDR_W-1:0]    wr_addr;
    logic [ADDR_W-1:0]    rd_addr;
    logic [CNT_W-1:0]     done_cnt;
    logic                 rx_active;
    logic                 trig_accept;

    assign ucmd = '{wr: usb_wr_en, done: usb_pkt_done};
    assign ccmd = '{rd: cpu_rd_en, trig: cpu_trig, clear: cpu_clear};

    rxpp_usb_side #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_usb (
        .clk         (clk),
        .rst         (rst),
        .cmd         (ucmd),
        .bank_full   (bank_full),
        .busy        (usb_busy),
        .tgt         (tgt),
        .wr_accept   (wr_accept),
        .done_accept (done_accept),
        .wr_addr     (wr_addr),
        .done_cnt    (done_cnt),
        .rx_active   (rx_active)
    );

    rxpp_cpu_side #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cpu (
        .clk         (clk),
        .rst         (rst),
        .cmd         (ccmd),
        .rx_size     (rx_size),
        .cpu_sel     (cpu_sel),
        .rd_addr     (rd_addr),
        .rd_err      (cpu_rd_err),
        .trig_accept (trig_accept)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic is_tgt;
        logic is_cpu;
        logic protect;
        logic rel;

        assign is_tgt  = (tgt == bank_id_t'(b));
        assign is_cpu  = (cpu_sel == bank_id_t'(b));
        assign protect = rx_active && is_tgt;
        assign rel     = (trig_accept && is_cpu) || (cpu_clear && !protect);

        rxpp_bank #(.DATA_W(DATA_W), .DEPTH(MAX_PKT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_accept && is_tgt),
            .wr_addr   (wr_addr),
            .wr_data   (usb_wr_data),
            .set_full  (done_accept && is_tgt),
            .set_cnt   (done_cnt),
            .release_i (rel),
            .rd_addr   (rd_addr),
            .rd_data   (bank_data[b]),
            .full      (bank_full[b]),
            .cnt       (bank_cnt[b])
        );
    end

    assign rx_size     = bank_full[cpu_sel] ? bank_cnt[cpu_sel] : '0;
    assign cpu_rd_data = bank_data[cpu_sel];

endmodule

// File: rtl/rxpp_chk.sv
module rxpp_chk #(
    parameter int CNT_W   = 7,
    parameter int MAX_PKT = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             usb_pkt_done,
    input logic             usb_busy,
    input logic             cpu_rd_en,
    input logic             cpu_trig,
    input logic             cpu_clear,
    input logic             cpu_rd_err,
    input logic [CNT_W-1:0] rx_size,
    input logic [1:0]       bank_full,
    input logic             cpu_sel,
    input logic             rx_active
);

    // R4
    overread_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd_en && rx_size == '0) |=> cpu_rd_err);

    // R4
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_err |-> $past(cpu_rd_en));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (usb_busy && !cpu_trig && !cpu_clear) |=> (bank_full == 2'b11));

    // R5
    trig_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_trig && !cpu_clear) |=> (cpu_sel != $past(cpu_sel)));

    // R8
    clear_spare_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_clear && rx_active && !usb_pkt_done) |=> rx_active);

    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_clear && !rx_active && !usb_pkt_done) |=> (bank_full == 2'b00));

    // R9
    size_cap_chk: assert property (@(posedge clk) disable iff (rst)
        rx_size <= CNT_W'(MAX_PKT));

    // R2
    done_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (usb_pkt_done && !usb_busy) |=> (bank_full != 2'b00));

endmodule

bind rx_pingpong_fifo rxpp_chk #(.CNT_W(CNT_W), .MAX_PKT(MAX_PKT)) u_rxpp_chk (
    .clk          (clk),
    .rst          (rst),
    .usb_pkt_done (usb_pkt_done),
    .usb_busy     (usb_busy),
    .cpu_rd_en    (cpu_rd_en),
    .cpu_trig     (cpu_trig),
    .cpu_clear    (cpu_clear),
    .cpu_rd_err   (cpu_rd_err),
    .rx_size      (rx_size),
    .bank_full    (bank_full),
    .cpu_sel      (cpu_sel),
    .rx_active    (rx_active)
);

// File: tb/test_rx_pingpong_fifo.sv
module test_rx_pingpong_fifo;

    localparam int CLK_P   = 10;
    localparam int DATA_W  = 8;
    localparam int MAX_PKT = 8;
    localparam int CNT_W   = $clog2(MAX_PKT + 1);

    logic              clk;
    logic              rst;
    logic              usb_wr_en;
    logic [DATA_W-1:0] usb_wr_data;
    logic              usb_pkt_done;
    logic              usb_busy;
    logic              cpu_rd_en;
    logic [DATA_W-1:0] cpu_rd_data;
    logic              cpu_rd_err;
    logic              cpu_trig;
    logic              cpu_clear;
    logic [CNT_W-1:0]  rx_size;

    int                checks = 0;
    int                errors = 0;
    logic [DATA_W-1:0] exp_q [$];
    logic              mon_on = 1'b0;
    bit                finished = 1'b0;

    rx_pingpong_fifo #(.DATA_W(DATA_W), .MAX_PKT(MAX_PKT)) i_rx_pingpong_fifo (
        .clk          (clk),
        .rst          (rst),
        .usb_wr_en    (usb_wr_en),
        .usb_wr_data  (usb_wr_data),
        .usb_pkt_done (usb_pkt_done),
        .usb_busy     (usb_busy),
        .cpu_rd_en    (cpu_rd_en),
        .cpu_rd_data  (cpu_rd_data),
        .cpu_rd_err   (cpu_rd_err),
        .cpu_trig     (cpu_trig),
        .cpu_clear    (cpu_clear),
        .rx_size      (rx_size)
    );

    initial clk = 1'b0;
    always #(CLK_P / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: compares each consumed byte against the scoreboard
    always @(negedge clk) begin : mon
        logic [DATA_W-1:0] e;
        if (mon_on && cpu_rd_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 (unexpected byte)", int'(cpu_rd_data), -1);
            end else begin
                e = exp_q.pop_front();
                check(cpu_rd_data == e, "R3/R6 data order", int'(cpu_rd_data), int'(e));
            end
        end
    end

    task automatic usb_bytes(input int n, input int base, input bit keep);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            usb_wr_en   = 1'b1;
            usb_wr_data = DATA_W'(base + i);
            if (keep && i < MAX_PKT) exp_q.push_back(DATA_W'(base + i));
        end
        @(posedge clk); #1;
        usb_wr_en = 1'b0;
    endtask

    task automatic usb_done();
        @(posedge clk); #1;
        usb_pkt_done = 1'b1;
        @(posedge clk); #1;
        usb_pkt_done = 1'b0;
    endtask

    task automatic usb_pkt(input int n, input int base);
        usb_bytes(n, base, 1'b1);
        usb_done();
    endtask

    task automatic cpu_drain();
        int n;
        @(negedge clk);
        n = int'(rx_size);
        @(posedge clk); #1;
        mon_on = 1'b1;
        for (int i = 0; i < n; i++) begin
            cpu_rd_en = 1'b1;
            @(posedge clk); #1;
        end
        cpu_rd_en = 1'b0;
        mon_on    = 1'b0;
    endtask

    task automatic pulse_trig();
        @(posedge clk); #1;
        cpu_trig = 1'b1;
        @(posedge clk); #1;
        cpu_trig = 1'b0;
    endtask

    task automatic pulse_clear();
        @(posedge clk); #1;
        cpu_clear = 1'b1;
        @(posedge clk); #1;
        cpu_clear = 1'b0;
    endtask

    task automatic overread();
        logic [DATA_W-1:0] held;
        @(negedge clk);
        held = cpu_rd_data;
        @(posedge clk); #1;
        cpu_rd_en = 1'b1;
        @(posedge clk); #1;
        cpu_rd_en = 1'b0;
        @(negedge clk);
        check(cpu_rd_err == 1'b1, "R4 error pulse", int'(cpu_rd_err), 1);
        check(cpu_rd_data == held, "R4 pointer held", int'(cpu_rd_data), int'(held));
        @(negedge clk);
        check(cpu_rd_err == 1'b0, "R4 pulse ends", int'(cpu_rd_err), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int lens [3];
        int prev_len;
        lens = '{4, 7, 2};
        rst = 1'b1;
        usb_wr_en = 1'b0;
        usb_wr_data = '0;
        usb_pkt_done = 1'b0;
        cpu_rd_en = 1'b0;
        cpu_trig = 1'b0;
        cpu_clear = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        check(rx_size == 0, "R1 size", int'(rx_size), 0);
        check(usb_busy == 1'b0, "R1 busy", int'(usb_busy), 0);
        check(cpu_rd_err == 1'b0, "R1 err", int'(cpu_rd_err), 0);

        // R2: first packet lands in the processor's buffer
        usb_pkt(5, 8'h10);
        @(negedge clk);
        check(rx_size == 5, "R2 count", int'(rx_size), 5);
        check(usb_busy == 1'b0, "R2 one bank free", int'(usb_busy), 0);
        cpu_drain();
        check(exp_q.size() == 0, "R3 all bytes read", exp_q.size(), 0);
        overread();

        // R5: other bank empty
        pulse_trig();
        @(negedge clk);
        check(rx_size == 0, "R5 empty peer", int'(rx_size), 0);

        // back-to-back fill of both banks
        usb_pkt(3, 8'h20);
        @(negedge clk);
        check(rx_size == 3, "R2 count in owned bank", int'(rx_size), 3);
        usb_pkt(6, 8'h30);
        @(negedge clk);
        check(rx_size == 3, "R6 peer fill leaves size", int'(rx_size), 3);
        check(usb_busy == 1'b1, "R7 busy when both full", int'(usb_busy), 1);
        cpu_drain();
        pulse_trig();
        @(negedge clk);
        check(rx_size == 6, "R5 size after switch", int'(rx_size), 6);
        check(usb_busy == 1'b0, "R7 busy released", int'(usb_busy), 0);

        // R6: fill one bank while draining the other
        prev_len = 6;
        for (int k = 0; k < 3; k++) begin
            fork
                usb_pkt(lens[k], 8'h40 + 16 * k);
                cpu_drain();
            join
            pulse_trig();
            @(negedge clk);
            check(rx_size == CNT_W'(lens[k]), "R6 alternating size", int'(rx_size), lens[k]);
            prev_len = lens[k];
        end

        // R7: refused traffic while both banks are full
        usb_pkt(5, 8'h80);
        @(negedge clk);
        check(usb_busy == 1'b1, "R7 busy", int'(usb_busy), 1);
        usb_bytes(3, 8'h90, 1'b0);
        usb_done();
        @(negedge clk);
        check(usb_busy == 1'b1, "R7 still busy", int'(usb_busy), 1);
        check(rx_size == CNT_W'(prev_len), "R7 size untouched", int'(rx_size), prev_len);
        cpu_drain();
        pulse_trig();
        @(negedge clk);
        check(rx_size == 5, "R7 dropped packet absent", int'(rx_size), 5);

        // R8: clear while a packet is part-way in
        usb_bytes(3, 8'hA0, 1'b1);
        pulse_clear();
        @(negedge clk);
        check(rx_size == 0, "R8 owned bank cleared", int'(rx_size), 0);
        for (int i = 0; i < 5; i++) void'(exp_q.pop_front());
        usb_bytes(2, 8'hA3, 1'b1);
        usb_done();
        @(negedge clk);
        check(rx_size == 0, "R8 owned bank still empty", int'(rx_size), 0);
        check(usb_busy == 1'b0, "R8 not busy", int'(usb_busy), 0);
        pulse_trig();
        @(negedge clk);
        check(rx_size == 5, "R8 receiving bank kept", int'(rx_size), 5);
        cpu_drain();
        check(exp_q.size() == 0, "R8 all bytes read", exp_q.size(), 0);

        // R9: oversize packet truncated
        usb_pkt(11, 8'hB0);
        pulse_trig();
        @(negedge clk);
        check(rx_size == CNT_W'(MAX_PKT), "R9 count capped", int'(rx_size), MAX_PKT);
        cpu_drain();
        check(exp_q.size() == 0, "R9 bytes read", exp_q.size(), 0);
        overread();
        pulse_trig();
        @(negedge clk);
        check(rx_size == 0, "R5 switch to empty bank", int'(rx_size), 0);

        finish_run();
    end

endmodule